// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an 8-bit general-purpose I/O port that a processor reaches through a small register bus. Three registers control it: an output latch, a direction register and a pull-resistor enable register. For each pin it drives a pad output value, an output-enable, and separate pullup and pulldown enables. The pin inputs pass through a two-flop synchronizer before they reach the read path.

When software reads the data register, each bit's source depends on its direction. Output pins return the latched value, and input pins return the synchronized pin level. Pull devices act only on input pins. On the upper pins, an external keyboard-interrupt function can claim the pin. When that function senses rising edges or high levels, the pull enable turns on a pulldown instead of a pullup.

The bus has a 2-bit address, a one-cycle write strobe and combinational read data. Address 0 selects the data latch, address 1 the direction register, address 2 the pull-enable register, and address 3 is unused.

Top module: `gpio_bidir_port`

## Requirements
- R1: After reset, the data latch, the direction register and the pull-enable register all read 0. `pad_oe`, `pad_pu_en` and `pad_pd_en` are all 0.
- R2: A write to address 0 stores all eight bits into the latch, whatever the direction bits are, and `pad_out` shows the latch from the next cycle. A write to address 1 sets `pad_oe` (1 = output) from the next cycle.
- R3: For a pin whose direction bit is 0, a read of address 0 returns that bit's pin level as it stood two rising clock edges earlier.
- R4: For a pin whose direction bit is 1, a read of address 0 returns the latched bit and never the pin level.
- R5: Addresses 1 and 2 read back exactly the value last written to them. Address 3 always reads 0, and a write to it changes no register.
- R6: An input pin whose pull bit is 1 has its pullup enabled, unless R8 selects the pulldown. A pull bit of 0 disables both pull devices.
- R7: A pin whose direction bit is 1 has both pull enables at 0, whatever its pull bit is.
- R8: On bits 7 to 4, when `kbd_en` and `kbd_rise` are both 1 for the bit, an enabled pull turns on the pulldown instead of the pullup. On bits 3 to 0, `kbd_en` and `kbd_rise` have no effect.
- R9: No pin ever has its pullup and pulldown enabled at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 pull enable, 3 unused |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 8 | Pin levels from the pads (asynchronous) |
| kbd_en | input | 8 | Per-bit keyboard-interrupt claim (bits 7 to 4 used) |
| kbd_rise | input | 8 | Per-bit sense polarity: 1 = rising edge / high level |
| pad_out | output | 8 | Value driven to the pads |
| pad_oe | output | 8 | Pad output enable, 1 = drive |
| pad_pu_en | output | 8 | Pullup enable per pad |
| pad_pd_en | output | 8 | Pulldown enable per pad |

## Verification
The bench writes the latch while pins are inputs and then turns them into outputs. A latch that stored only the output bits would then show stale zeros. It changes a pin and reads it after one and then two edges. A missing or extra synchronizer stage would show up as a one-cycle shift. It drives pin levels that differ from the latch on output bits, which exposes a read mux that takes its select from the wrong source. It also mixes keyboard-interrupt claim and polarity across the upper and lower nibbles, with some pins set as outputs. A swapped pullup/pulldown choice, a pull left on for an output, or a lower bit that obeyed the keyboard inputs would each show up as a wrong pull-enable vector.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_PULL = 2'd2,
        REG_NONE = 2'd3
    } gpio_reg_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= pin_async;
            stage2_q <= stage1_q;
        end
    end

    assign pin_sync = stage2_q;

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpio_reg_e        addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pull_q
);

    logic [WIDTH-1:0] data_d;
    logic [WIDTH-1:0] dir_d;
    logic [WIDTH-1:0] pull_d;

    // register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            pull_q <= '0;
        end else begin
            data_q <= data_d;
            dir_q  <= dir_d;
            pull_q <= pull_d;
        end
    end

    // next-value process: a write updates one whole register, regardless of direction
    always_comb begin
        data_d = data_q;
        dir_d  = dir_q;
        pull_d = pull_q;
        if (wr_en) begin
            unique case (addr)
                REG_DATA: data_d = wdata;
                REG_DIR:  dir_d  = wdata;
                REG_PULL: pull_d = wdata;
                REG_NONE: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_pull_ctrl.sv
module gpio_pull_ctrl #(
    parameter int WIDTH  = 8,
    parameter int KBD_LO = 4
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pull_q,
    input  logic [WIDTH-1:0] kbd_en,
    input  logic [WIDTH-1:0] kbd_rise,
    output logic [WIDTH-1:0] pu_en,
    output logic [WIDTH-1:0] pd_en
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam bit KBD_CAPABLE = (i >= KBD_LO);
        logic pull_active;
        logic want_down;

        assign pull_active = pull_q[i] & ~dir_q[i];
        assign want_down   = KBD_CAPABLE & kbd_en[i] & kbd_rise[i];
        assign pu_en[i]    = pull_active & ~want_down;
        assign pd_en[i]    = pull_active &  want_down;
    end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  gpio_reg_e        addr,
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pull_q,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] data_view;

    // per bit: outputs show the latch, inputs show the synchronized pin
    for (genvar i = 0; i < WIDTH; i++) begin : g_view
        assign data_view[i] = dir_q[i] ? data_q[i] : pin_sync[i];
    end

    always_comb begin
        unique case (addr)
            REG_DATA: rdata = data_view;
            REG_DIR:  rdata = dir_q;
            REG_PULL: rdata = pull_q;
            REG_NONE: rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bidir_port.sv
module gpio_bidir_port
    import gpio_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int KBD_LO = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] kbd_en,
    input  logic [WIDTH-1:0] kbd_rise,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu_en,
    output logic [WIDTH-1:0] pad_pd_en
);

    gpio_reg_e        reg_sel;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pull_q;
    logic [WIDTH-1:0] pin_sync;

    assign reg_sel = gpio_reg_e'(bus_addr);

    gpio_regfile #(.WIDTH(WIDTH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (reg_sel),
        .wdata  (bus_wdata),
        .data_q (data_q),
        .dir_q  (dir_q),
        .pull_q (pull_q)
    );

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .pin_sync  (pin_sync)
    );

    gpio_read_mux #(.WIDTH(WIDTH)) u_rmux (
        .addr     (reg_sel),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .pull_q   (pull_q),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata)
    );

    gpio_pull_ctrl #(.WIDTH(WIDTH), .KBD_LO(KBD_LO)) u_pull (
        .dir_q    (dir_q),
        .pull_q   (pull_q),
        .kbd_en   (kbd_en),
        .kbd_rise (kbd_rise),
        .pu_en    (pad_pu_en),
        .pd_en    (pad_pd_en)
    );

    assign pad_out = data_q;
    assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_bidir_port_chk.sv
module gpio_bidir_port_chk #(
    parameter int WIDTH  = 8,
    parameter int KBD_LO = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_pu_en,
    input logic [WIDTH-1:0] pad_pd_en
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_pu_en == '0 && pad_pd_en == '0)); // R1

    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> pad_out == $past(bus_wdata)); // R2

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> pad_oe == $past(bus_wdata)); // R2

    AST_SPARE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 2'd3 |-> bus_rdata == '0); // R5

    AST_SPARE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3) |=> ($stable(pad_out) && $stable(pad_oe))); // R5

    AST_OUTPUT_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & (pad_pu_en | pad_pd_en)) == '0); // R7

    AST_LOW_NO_PULLDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        pad_pd_en[KBD_LO-1:0] == '0); // R8

    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu_en & pad_pd_en) == '0); // R9

endmodule

bind gpio_bidir_port gpio_bidir_port_chk #(.WIDTH(WIDTH), .KBD_LO(KBD_LO)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu_en (pad_pu_en),
    .pad_pd_en (pad_pd_en)
);

// File: tb/tb_gpio_bidir_port.sv
`timescale 1ns/1ps
module tb_gpio_bidir_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] kbd_en = 8'h00;
    logic [7:0] kbd_rise = 8'h00;
    logic [7:0] pad_out, pad_oe, pad_pu_en, pad_pd_en;

    gpio_bidir_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .kbd_en(kbd_en), .kbd_rise(kbd_rise), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu_en(pad_pu_en), .pad_pd_en(pad_pd_en)
    );

    always #2.5 clk = ~clk;

    // kinds: 0 rdata, 1 pad_out, 2 pad_oe, 3 pullup, 4 pulldown, 5 pullup&pulldown
    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    function automatic logic [7:0] observe(input int kind);
        case (kind)
            0:       return bus_rdata;
            1:       return pad_out;
            2:       return pad_oe;
            3:       return pad_pu_en;
            4:       return pad_pd_en;
            default: return pad_pu_en & pad_pd_en;
        endcase
    endfunction

    // monitor: compares queued expectations midway between rising edges
    always @(negedge clk) begin
        while (q.size() != 0) begin
            exp_t       it;
            logic [7:0] act;
            it  = q.pop_front();
            act = observe(it.kind);
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic exp_pad(input int kind, input logic [7:0] e, input string tag);
        q.push_back('{kind, e, tag});
    endtask

    task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        bus_addr = a;
        q.push_back('{0, e, tag});
        tick();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state
        exp_pad(2, 8'h00, "R1");
        exp_pad(3, 8'h00, "R1");
        exp_pad(4, 8'h00, "R1");
        exp_rd(2'd0, 8'h00, "R1");
        exp_rd(2'd1, 8'h00, "R1");
        exp_rd(2'd2, 8'h00, "R1");

        // R2: latch written while upper pins are inputs
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'hA5);
        exp_pad(1, 8'hA5, "R2");
        exp_pad(2, 8'h0F, "R2");
        exp_rd(2'd0, 8'h05, "R4");
        wr(2'd1, 8'hFF);
        exp_rd(2'd0, 8'hA5, "R2");
        wr(2'd1, 8'h0F);

        // R3/R4: two-edge latency on inputs, outputs ignore the pin
        pin_in = 8'h3C;
        exp_rd(2'd0, 8'h05, "R3");
        exp_rd(2'd0, 8'h05, "R3");
        exp_rd(2'd0, 8'h35, "R3");
        exp_rd(2'd0, 8'h35, "R4");

        // R5: readback and spare address
        wr(2'd2, 8'hFF);
        exp_rd(2'd2, 8'hFF, "R5");
        exp_rd(2'd1, 8'h0F, "R5");
        wr(2'd3, 8'h77);
        exp_rd(2'd3, 8'h00, "R5");
        exp_rd(2'd0, 8'h35, "R5");
        exp_rd(2'd1, 8'h0F, "R5");
        exp_rd(2'd2, 8'hFF, "R5");
        exp_pad(1, 8'hA5, "R5");

        // R6/R7: pullups on inputs only
        exp_pad(3, 8'hF0, "R6");
        exp_pad(4, 8'h00, "R7");
        tick();

        // R8: keyboard claim with rising sense
        kbd_en = 8'hFF; kbd_rise = 8'hFF;
        exp_pad(3, 8'h00, "R7");
        exp_pad(4, 8'hF0, "R8");
        tick();
        wr(2'd1, 8'h00);
        exp_pad(3, 8'h0F, "R8");
        exp_pad(4, 8'hF0, "R8");
        exp_pad(5, 8'h00, "R9");
        tick();
        kbd_en = 8'hA0; kbd_rise = 8'hF0;
        exp_pad(3, 8'h5F, "R8");
        exp_pad(4, 8'hA0, "R8");
        tick();
        kbd_en = 8'hF0; kbd_rise = 8'h30;
        exp_pad(3, 8'hCF, "R8");
        exp_pad(4, 8'h30, "R8");
        exp_pad(5, 8'h00, "R9");
        tick();

        // R6/R7/R8 mixed: partial pulls, one output among claimed bits
        kbd_rise = 8'hF0;
        wr(2'd2, 8'h3C);
        wr(2'd1, 8'h10);
        exp_pad(3, 8'h0C, "R6");
        exp_pad(4, 8'h20, "R7");
        tick();
        wr(2'd2, 8'h00);
        exp_pad(3, 8'h00, "R6");
        exp_pad(4, 8'h00, "R6");
        tick();

        // R8: lower bits ignore keyboard inputs
        wr(2'd2, 8'h0F);
        kbd_en = 8'h0F; kbd_rise = 8'h0F;
        exp_pad(3, 8'h0F, "R8");
        exp_pad(4, 8'h00, "R8");
        tick();

        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule